// File: doc/BRIEF.md
# Dual-CPU Peripheral Clock Gate

This block decides, for a single peripheral that two processors share, whether the peripheral's register-access (bus) clock and its functional (kernel) clock may run. Each processor owns an enable bit and a keep-in-sleep bit for the peripheral. The block combines these bits with each processor's power state, the power state of the whole system and the code of the oscillator that drives the kernel clock. It then drives gate-enable outputs that a clock-gating cell downstream of it uses.

Every gate decision passes through a two-flop synchronizer before it reaches an output, so a gate opens or closes only on a clean clock edge. This holds when a gate opens and when it closes. A separate real-time-clock gate follows only its own enable bit and passes through the same two flops. A status output tells the bus side whether register accesses to the peripheral can be served.

Top module: `periph_clk_gate`

## Requirements
- R1: When neither processor's enable bit is set, bus_clk_en and kern_clk_en are both 0 in every processor and system power state.
- R2: With the system in run (sys_mode 2'd0), a processor in run (mode 2'd0) whose enable bit is set makes bus_clk_en and kern_clk_en both 1.
- R3: A processor in sleep (mode 2'd1) contributes to the bus clock only when both its enable bit and its keep-in-sleep bit are set. With only the enable bit set it contributes to the kernel clock but not to the bus clock.
- R4: A processor in deep stop (mode 2'd2 or 2'd3) while the system runs contributes no bus clock, but its set enable bit still makes kern_clk_en 1.
- R5: In system stop (sys_mode 2'd1), bus_clk_en is 0. kern_clk_en is 1 when an enable bit is set and kclk_src is 3'd4 (16 MHz internal RC), 3'd5 (low-speed internal RC) or 3'd6 (low-speed crystal). It is 0 for 3'd0 (bus clock), 3'd1 (system clock), 3'd2 (PLL), 3'd3 (multi-speed RC) and 3'd7.
- R6: In standby (sys_mode 2'd2) or shutdown (sys_mode 2'd3), bus_clk_en and kern_clk_en are both 0.
- R7: After an input change that opens a gate, the output stays 0 after the first rising clock edge and becomes 1 after the second.
- R8: After an input change that closes a gate, the output stays 1 after the first rising clock edge and becomes 0 after the second.
- R9: rtc_clk_en follows rtc_en with the same two-edge delay and does not depend on processor modes, system mode or the other enable bits.
- R10: The final bus and kernel enables are the OR of the two processors' contributions: one processor can keep a clock running while the other does not request it.
- R11: When the parameter HAS_KERNEL is 0, kern_clk_en is always 0 and bus gating is unchanged.
- R12: bus_ready equals bus_clk_en in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the gate synchronizer |
| rst_n | input | 1 | Active-low asynchronous reset, all gates closed |
| a_en | input | 1 | Processor A peripheral enable bit |
| a_slp_en | input | 1 | Processor A keep-in-sleep bit |
| a_mode | input | 2 | Processor A power state: 0 run, 1 sleep, 2/3 deep stop |
| b_en | input | 1 | Processor B peripheral enable bit |
| b_slp_en | input | 1 | Processor B keep-in-sleep bit |
| b_mode | input | 2 | Processor B power state, same encoding as a_mode |
| sys_mode | input | 2 | System state: 0 run, 1 stop, 2 standby, 3 shutdown |
| kclk_src | input | 3 | Kernel clock source code (see R5) |
| rtc_en | input | 1 | Real-time-clock kernel gate enable bit |
| bus_clk_en | output | 1 | Bus clock gate enable |
| kern_clk_en | output | 1 | Kernel clock gate enable |
| rtc_clk_en | output | 1 | Real-time-clock kernel gate enable |
| bus_ready | output | 1 | Bus access can be served (bus clock running) |

## Verification
A wrong gate decision shows at bus_clk_en or kern_clk_en exactly two rising edges after the input pattern that exposes it, so each scenario samples after the second edge. A wrong synchronizer depth shows as an output that changes one edge early or late. For that reason, the opening and closing of each gate are sampled after both the first and the second edge. A real-time-clock gate that is wrongly tied to the power states shows as rtc_clk_en dropping during stop, standby or shutdown, within the same two edges.

// File: rtl/periph_clk_gate.sv
module periph_clk_gate #(
  parameter bit HAS_KERNEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_en,
  input  logic       a_slp_en,
  input  logic [1:0] a_mode,
  input  logic       b_en,
  input  logic       b_slp_en,
  input  logic [1:0] b_mode,
  input  logic [1:0] sys_mode,
  input  logic [2:0] kclk_src,
  input  logic       rtc_en,
  output logic       bus_clk_en,
  output logic       kern_clk_en,
  output logic       rtc_clk_en,
  output logic       bus_ready
);

  localparam logic [1:0] CPU_RUN   = 2'd0;
  localparam logic [1:0] CPU_SLEEP = 2'd1;
  localparam logic [1:0] SYS_RUN   = 2'd0;
  localparam logic [1:0] SYS_STOP  = 2'd1;
  localparam int         NGATE     = 3;

  logic a_bus, b_bus, any_en, src_alive;
  logic bus_raw, kern_raw;
  logic [NGATE-1:0] raw, st1, st2;

  assign a_bus = a_en && (a_mode == CPU_RUN || (a_mode == CPU_SLEEP && a_slp_en));
  assign b_bus = b_en && (b_mode == CPU_RUN || (b_mode == CPU_SLEEP && b_slp_en));
  assign any_en = a_en || b_en;
  assign src_alive = (kclk_src == 3'd4) || (kclk_src == 3'd5) || (kclk_src == 3'd6);

  assign bus_raw = (sys_mode == SYS_RUN) && (a_bus || b_bus);

  generate
    if (HAS_KERNEL) begin : g_kern
      assign kern_raw = any_en &&
                        ((sys_mode == SYS_RUN) || (sys_mode == SYS_STOP && src_alive));
    end else begin : g_nokern
      assign kern_raw = 1'b0;
    end
  endgenerate

  assign raw = {rtc_en, kern_raw, bus_raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= raw;
      st2 <= st1;
    end
  end

  assign bus_clk_en  = st2[0];
  assign kern_clk_en = st2[1];
  assign rtc_clk_en  = st2[2];
  assign bus_ready   = st2[0];

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!a_en && !b_en, 2) |-> (!bus_clk_en && !kern_clk_en));

  assert_no_bus_in_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_mode != SYS_RUN, 2) |-> !bus_clk_en);

  assert_all_off_deep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sys_mode[1], 2) |-> (!bus_clk_en && !kern_clk_en));

  assert_bus_open_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk_en) |-> $past(bus_raw, 2));

  assert_bus_close_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk_en) |-> !$past(bus_raw, 2));

  assert_rtc_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rtc_en, 2) == rtc_clk_en);

  assert_ready_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready == bus_clk_en);

  generate
    if (!HAS_KERNEL) begin : g_chk_nokern
      always_comb assert_no_kernel_R11: assert (kern_clk_en == 1'b0);
    end
  endgenerate

endmodule

// File: tb/periph_clk_gate_tb.sv
module periph_clk_gate_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_slp_en = 0, b_en = 0, b_slp_en = 0, rtc_en = 0;
  logic [1:0] a_mode = 0, b_mode = 0, sys_mode = 0;
  logic [2:0] kclk_src = 0;
  logic bus_clk_en, kern_clk_en, rtc_clk_en, bus_ready;
  logic nk_bus, nk_kern, nk_rtc, nk_ready;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  periph_clk_gate u_dut (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_slp_en(a_slp_en), .a_mode(a_mode),
    .b_en(b_en), .b_slp_en(b_slp_en), .b_mode(b_mode), .sys_mode(sys_mode),
    .kclk_src(kclk_src), .rtc_en(rtc_en), .bus_clk_en(bus_clk_en),
    .kern_clk_en(kern_clk_en), .rtc_clk_en(rtc_clk_en), .bus_ready(bus_ready));

  periph_clk_gate #(.HAS_KERNEL(1'b0)) u_dut_nk (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_slp_en(a_slp_en), .a_mode(a_mode),
    .b_en(b_en), .b_slp_en(b_slp_en), .b_mode(b_mode), .sys_mode(sys_mode),
    .kclk_src(kclk_src), .rtc_en(rtc_en), .bus_clk_en(nk_bus),
    .kern_clk_en(nk_kern), .rtc_clk_en(nk_rtc), .bus_ready(nk_ready));

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic ae, input logic as, input logic [1:0] am,
                       input logic be, input logic bs, input logic [1:0] bm,
                       input logic [1:0] sm, input logic [2:0] src);
    @(negedge clk);
    a_en = ae; a_slp_en = as; a_mode = am;
    b_en = be; b_slp_en = bs; b_mode = bm;
    sys_mode = sm; kclk_src = src;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_gates(input string req, input logic eb, input logic ek);
    settle();
    chk({req, " bus"}, bus_clk_en, eb);
    chk({req, " kern"}, kern_clk_en, ek);
    chk({req, " R12 ready"}, bus_ready, eb);
  endtask

  task automatic t_reset();
    chk("R1 reset bus", bus_clk_en, 1'b0);
    chk("R1 reset kern", kern_clk_en, 1'b0);
    chk("R9 reset rtc", rtc_clk_en, 1'b0);
  endtask

  task automatic t_disabled();
    for (int m = 0; m < 4; m++) begin
      drive(0, 1, m[1:0], 0, 1, 2'd0, m[1:0], 3'd4);
      expect_gates("R1 disabled", 1'b0, 1'b0);
    end
  endtask

  task automatic t_run();
    drive(1, 0, 2'd0, 0, 0, 2'd2, 2'd0, 3'd0);
    expect_gates("R2 A run", 1'b1, 1'b1);
    drive(0, 0, 2'd2, 1, 0, 2'd0, 2'd0, 3'd1);
    expect_gates("R2 B run", 1'b1, 1'b1);
  endtask

  task automatic t_sleep();
    drive(1, 1, 2'd1, 0, 0, 2'd0, 2'd0, 3'd0);
    expect_gates("R3 sleep with keep", 1'b1, 1'b1);
    drive(1, 0, 2'd1, 0, 0, 2'd0, 2'd0, 3'd0);
    expect_gates("R3 sleep no keep", 1'b0, 1'b1);
  endtask

  task automatic t_deepstop();
    drive(1, 1, 2'd2, 0, 0, 2'd0, 2'd0, 3'd2);
    expect_gates("R4 deep stop A", 1'b0, 1'b1);
    drive(0, 0, 2'd0, 1, 1, 2'd3, 2'd0, 3'd2);
    expect_gates("R4 deep stop B", 1'b0, 1'b1);
  endtask

  task automatic t_sysstop();
    for (int s = 0; s < 8; s++) begin
      drive(1, 1, 2'd0, 1, 1, 2'd0, 2'd1, s[2:0]);
      expect_gates("R5 sys stop", 1'b0, (s >= 4 && s <= 6));
    end
  endtask

  task automatic t_standby();
    drive(1, 1, 2'd0, 1, 1, 2'd0, 2'd2, 3'd5);
    expect_gates("R6 standby", 1'b0, 1'b0);
    drive(1, 1, 2'd0, 1, 1, 2'd0, 2'd3, 3'd6);
    expect_gates("R6 shutdown", 1'b0, 1'b0);
  endtask

  task automatic t_timing();
    drive(0, 0, 2'd0, 0, 0, 2'd0, 2'd0, 3'd0);
    settle();
    drive(1, 0, 2'd0, 0, 0, 2'd0, 2'd0, 3'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 open after one edge", bus_clk_en, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R7 open after two edges", bus_clk_en, 1'b1);
    drive(0, 0, 2'd0, 0, 0, 2'd0, 2'd0, 3'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 close after one edge", bus_clk_en, 1'b1);
    chk("R8 kern close after one edge", kern_clk_en, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8 close after two edges", bus_clk_en, 1'b0);
    chk("R8 kern close after two edges", kern_clk_en, 1'b0);
  endtask

  task automatic t_rtc();
    drive(0, 0, 2'd2, 0, 0, 2'd2, 2'd3, 3'd0);
    @(negedge clk); rtc_en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 rtc after one edge", rtc_clk_en, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 rtc in shutdown", rtc_clk_en, 1'b1);
    drive(1, 1, 2'd0, 1, 1, 2'd0, 2'd1, 3'd0);
    settle();
    chk("R9 rtc in stop", rtc_clk_en, 1'b1);
    @(negedge clk); rtc_en = 1'b0;
    settle();
    chk("R9 rtc cleared", rtc_clk_en, 1'b0);
    chk("R9 rtc other gates", bus_clk_en, 1'b0);
  endtask

  task automatic t_or();
    drive(1, 0, 2'd1, 1, 0, 2'd0, 2'd0, 3'd0);
    expect_gates("R10 A sleep B run", 1'b1, 1'b1);
    drive(1, 0, 2'd1, 1, 1, 2'd1, 2'd0, 3'd0);
    expect_gates("R10 B keeps bus", 1'b1, 1'b1);
  endtask

  task automatic t_nokern();
    drive(1, 0, 2'd0, 0, 0, 2'd0, 2'd0, 3'd4);
    settle();
    chk("R11 no kernel in run", nk_kern, 1'b0);
    chk("R11 bus still gated", nk_bus, 1'b1);
    drive(1, 0, 2'd2, 0, 0, 2'd0, 2'd1, 3'd4);
    settle();
    chk("R11 no kernel in stop", nk_kern, 1'b0);
    chk("R11 bus off", nk_bus, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_run();
    t_sleep();
    t_deepstop();
    t_sysstop();
    t_standby();
    t_timing();
    t_rtc();
    t_or();
    t_nokern();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule